// File: doc/BRIEF.md
# Alternate Bus-Master Acquisition Handshake

This block is the arbitration front end of a device that takes over a shared bus from the resident processor. A local engine raises `need_bus_i`. The block then pulls the shared request line and waits for the processor's grant. It watches the address strobe, the data acknowledge and the shared grant-acknowledge line. Once all three are idle, it claims the bus and reports ownership to the engine on `owner_o`. When the engine pulses `done_i`, the block gives the bus back.

The two shared lines driven by the block are wired-OR. Each output is a pull enable: high pulls the line to its active level and low releases it. The block works in one of two arbitration modes. In 3-wire mode, mastership is held through the grant-acknowledge line, and the request is dropped in the same cycle the acknowledge is raised. In 2-wire mode, the grant-acknowledge line is never driven, and the request stays pulled for the whole tenure. Releasing the request is what returns the bus. A configuration input removes the data-acknowledge term from the idle test. This suits systems where only the address strobe marks bus activity.

All four sensed bus lines pass through a two-flop synchronizer before any decision uses them.

Top module: `busmaster_acq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_pull_o`, `ack_pull_o` and `owner_o` are all low.
- R2: A high `need_bus_i` in idle makes `req_pull_o` high after the next clock edge. `ack_pull_o` and `owner_o` stay low.
- R3: Ownership is taken only when three conditions hold at once in the synchronized view: grant asserted, address strobe negated and grant-acknowledge line negated. A fourth condition applies when `chk_dack_i`=1: data acknowledge negated. `owner_o` rises on the third clock edge after the last of these conditions becomes true at the pins, given that the block is already waiting for idle.
- R4: `owner_o` never rises while the synchronized address strobe is asserted, however long the grant is held.
- R5: With `chk_dack_i`=0, an asserted data acknowledge does not block ownership.
- R6: In 3-wire mode (`two_wire_i`=0), `req_pull_o` falls on the same edge that `ack_pull_o` rises.
- R7: `owner_o` stays high until `done_i` is seen high at a clock edge, regardless of grant. On that edge `owner_o` and the pulled lines all drop. The block returns to idle one cycle later.
- R8: In 2-wire mode (`two_wire_i`=1), `ack_pull_o` is never raised. `req_pull_o` stays high throughout ownership and drops when `done_i` ends the tenure.
- R9: If the synchronized grant is lost before the idle condition is met, the block returns to requesting. It keeps `req_pull_o` high and does not raise `ack_pull_o`. A later grant is handled normally.
- R10: `two_wire_i` is sampled when a request starts. Changing it during a tenure has no effect on the lines driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| two_wire_i | input | 1 | 1 = 2-wire arbitration, 0 = 3-wire |
| chk_dack_i | input | 1 | 1 = include data acknowledge in idle test |
| need_bus_i | input | 1 | Local engine wants the bus |
| done_i | input | 1 | Local engine finished its last bus cycle |
| grant_i | input | 1 | Bus grant from processor, active high (asynchronous) |
| strobe_i | input | 1 | Address strobe asserted (asynchronous) |
| dack_i | input | 1 | Data acknowledge asserted (asynchronous) |
| ack_line_i | input | 1 | Shared grant-acknowledge line asserted (asynchronous) |
| req_pull_o | output | 1 | Pull the shared request line active |
| ack_pull_o | output | 1 | Pull the shared grant-acknowledge line active |
| owner_o | output | 1 | Block is bus master |

## Verification
The bench holds the address strobe, data acknowledge or another master's acknowledge active past the grant. It checks that ownership waits, and that it arrives exactly three edges after the last blocker clears. A design that skipped a term would grab the bus in the middle of a cycle, and one with the wrong synchronizer depth would be off by a cycle. Grant is withdrawn while the block waits for idle. A design that kept waiting, or that raised the acknowledge anyway, would be caught by the request and acknowledge checks. The 2-wire tenure is checked for a held request and a silent acknowledge line, including a mode flip during the tenure. A design that dropped the request early, or followed the live mode pin, would release the bus too soon.

// File: rtl/bma_pkg.sv
package bma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_WAIT = 3'd2,
    ST_OWN  = 3'd3,
    ST_REL  = 3'd4
  } bma_state_e;

  localparam int unsigned NUM_SENSE = 4;
endpackage

// File: rtl/bma_sync.sv
module bma_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= '0;
      else if (s == 0) pipe_q[s] <= d_i;
      else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/bma_idle_chk.sv
module bma_idle_chk (
  input  logic strb_s_i,
  input  logic dack_s_i,
  input  logic oack_s_i,
  input  logic chk_dack_i,
  output logic idle_o
);
  // Shared bus is free only when no strobe is active and no one holds mastership
  assign idle_o = !strb_s_i && !oack_s_i && !(chk_dack_i && dack_s_i);
endmodule

// File: rtl/bma_fsm.sv
module bma_fsm
  import bma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic two_wire_i,
  input  logic need_bus_i,
  input  logic done_i,
  input  logic grant_s_i,
  input  logic idle_i,
  output logic req_pull_o,
  output logic ack_pull_o,
  output logic owner_o
);
  bma_state_e state_q, state_d;
  logic mode_q, mode_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (need_bus_i) state_d = ST_REQ;
      ST_REQ:  if (grant_s_i) state_d = ST_WAIT;
      ST_WAIT: begin
        if (!grant_s_i)  state_d = ST_REQ;
        else if (idle_i) state_d = ST_OWN;
      end
      ST_OWN:  if (done_i) state_d = ST_REL;
      ST_REL:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Mode is frozen when a request starts
  assign mode_d = (state_q == ST_IDLE && need_bus_i) ? two_wire_i : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= 1'b0;
      req_pull_o <= 1'b0;
      ack_pull_o <= 1'b0;
      owner_o    <= 1'b0;
    end else begin
      state_q    <= state_d;
      mode_q     <= mode_d;
      req_pull_o <= (state_d == ST_REQ) || (state_d == ST_WAIT) ||
                    (state_d == ST_OWN && mode_d);
      ack_pull_o <= (state_d == ST_OWN) && !mode_d;
      owner_o    <= (state_d == ST_OWN);
    end
  end
endmodule

// File: rtl/busmaster_acq.sv
module busmaster_acq
  import bma_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic two_wire_i,
  input  logic chk_dack_i,
  input  logic need_bus_i,
  input  logic done_i,
  input  logic grant_i,
  input  logic strobe_i,
  input  logic dack_i,
  input  logic ack_line_i,
  output logic req_pull_o,
  output logic ack_pull_o,
  output logic owner_o
);
  logic [NUM_SENSE-1:0] sense_s;
  logic grant_s, strb_s, dack_s, oack_s, idle;

  bma_sync #(.WIDTH(NUM_SENSE), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({grant_i, strobe_i, dack_i, ack_line_i}),
    .q_o   (sense_s)
  );

  assign {grant_s, strb_s, dack_s, oack_s} = sense_s;

  bma_idle_chk u_idle (
    .strb_s_i  (strb_s),
    .dack_s_i  (dack_s),
    .oack_s_i  (oack_s),
    .chk_dack_i(chk_dack_i),
    .idle_o    (idle)
  );

  bma_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .two_wire_i(two_wire_i),
    .need_bus_i(need_bus_i),
    .done_i    (done_i),
    .grant_s_i (grant_s),
    .idle_i    (idle),
    .req_pull_o(req_pull_o),
    .ack_pull_o(ack_pull_o),
    .owner_o   (owner_o)
  );
endmodule

// File: rtl/busmaster_acq_chk.sv
module busmaster_acq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic chk_dack_i,
  input logic done_i,
  input logic req_pull_o,
  input logic ack_pull_o,
  input logic owner_o,
  input logic grant_s,
  input logic strb_s,
  input logic dack_s,
  input logic oack_s
);
  always_comb begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!req_pull_o && !ack_pull_o && !owner_o);
  end

  assert_take_when_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(owner_o) |-> ($past(grant_s) && !$past(oack_s) &&
                        !($past(chk_dack_i) && $past(dack_s))));

  assert_no_take_on_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(owner_o) |-> !$past(strb_s));

  assert_req_drop_on_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_pull_o) |-> $fell(req_pull_o));

  assert_hold_until_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_o && !done_i) |=> owner_o);

  assert_one_hold_line_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_o |-> (req_pull_o != ack_pull_o));

  assert_ack_needs_owner_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_pull_o |-> owner_o);
endmodule

bind busmaster_acq busmaster_acq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chk_dack_i(chk_dack_i),
  .done_i    (done_i),
  .req_pull_o(req_pull_o),
  .ack_pull_o(ack_pull_o),
  .owner_o   (owner_o),
  .grant_s   (grant_s),
  .strb_s    (strb_s),
  .dack_s    (dack_s),
  .oack_s    (oack_s)
);

// File: tb/busmaster_acq_test.sv
module busmaster_acq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic two_wire = 1'b0, chk_dack = 1'b1, need = 1'b0, done = 1'b0;
  logic grant = 1'b0, strobe = 1'b0, dack = 1'b0, other_ack = 1'b0;
  logic req_pull, ack_pull, owner;
  logic ack_line;
  int   n_run = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign ack_line = ack_pull | other_ack;

  busmaster_acq uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .two_wire_i(two_wire),
    .chk_dack_i(chk_dack),
    .need_bus_i(need),
    .done_i    (done),
    .grant_i   (grant),
    .strobe_i  (strobe),
    .dack_i    (dack),
    .ack_line_i(ack_line),
    .req_pull_o(req_pull),
    .ack_pull_o(ack_pull),
    .owner_o   (owner)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {req,ack,own} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; need = 0; done = 0; grant = 0; strobe = 0; dack = 0;
    other_ack = 0; two_wire = 0; chk_dack = 1;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic end_tenure(input string tag);
    done = 1'b1; need = 1'b0;
    tick(1);
    done = 1'b0; grant = 1'b0;
    check(tag, {req_pull, ack_pull, owner}, 3'b000);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; grant = 1; strobe = 1; need = 1;
    tick(1);
    check("R1 in reset", {req_pull, ack_pull, owner}, 3'b000);
    do_reset();
    check("R1 after reset", {req_pull, ack_pull, owner}, 3'b000);
  endtask

  task automatic t_three_wire();
    do_reset();
    need = 1;
    tick(1);
    check("R2 request", {req_pull, ack_pull, owner}, 3'b100);
    strobe = 1; grant = 1;
    tick(8);
    check("R4 strobe blocks", {req_pull, ack_pull, owner}, 3'b100);
    strobe = 0;
    tick(2);
    check("R3 not yet", {req_pull, ack_pull, owner}, 3'b100);
    tick(1);
    check("R3 R6 own", {req_pull, ack_pull, owner}, 3'b011);
    grant = 0;
    tick(5);
    check("R7 holds", {req_pull, ack_pull, owner}, 3'b011);
    end_tenure("R7 release");
    tick(1);
    check("R7 idle", {req_pull, ack_pull, owner}, 3'b000);
  endtask

  task automatic t_other_ack();
    do_reset();
    other_ack = 1; need = 1; grant = 1;
    tick(8);
    check("R3 other ack blocks", {req_pull, ack_pull, owner}, 3'b100);
    other_ack = 0;
    tick(2);
    check("R3 other ack edge-2", {req_pull, ack_pull, owner}, 3'b100);
    tick(1);
    check("R3 other ack own", {req_pull, ack_pull, owner}, 3'b011);
    end_tenure("R7 release");
  endtask

  task automatic t_dack();
    do_reset();
    chk_dack = 1; dack = 1; need = 1; grant = 1;
    tick(8);
    check("R3 dack blocks", {req_pull, ack_pull, owner}, 3'b100);
    chk_dack = 0;
    tick(1);
    check("R5 dack ignored", {req_pull, ack_pull, owner}, 3'b011);
    end_tenure("R7 release");
    dack = 0; chk_dack = 1;
  endtask

  task automatic t_grant_lost();
    do_reset();
    need = 1; strobe = 1; grant = 1;
    tick(6);
    grant = 0;
    tick(3);
    strobe = 0;
    tick(6);
    check("R9 back to request", {req_pull, ack_pull, owner}, 3'b100);
    grant = 1;
    tick(3);
    check("R9 regrant wait", {req_pull, ack_pull, owner}, 3'b100);
    tick(1);
    check("R9 regrant own", {req_pull, ack_pull, owner}, 3'b011);
    end_tenure("R7 release");
  endtask

  task automatic t_two_wire();
    do_reset();
    two_wire = 1; need = 1;
    tick(1);
    check("R8 request", {req_pull, ack_pull, owner}, 3'b100);
    grant = 1;
    tick(4);
    check("R8 own", {req_pull, ack_pull, owner}, 3'b101);
    two_wire = 0;
    tick(5);
    check("R10 mode frozen", {req_pull, ack_pull, owner}, 3'b101);
    end_tenure("R8 release");
  endtask

  initial begin
    t_reset();
    t_three_wire();
    t_other_ack();
    t_dack();
    t_grant_lost();
    t_two_wire();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule